// File: doc/BRIEF.md
# Single-Operand Shift and Rotate ALU

This unit executes the one-operand operations of an 8-bit accumulator machine: negate, ones' complement, logical and arithmetic right shift, left shift, rotate right and left through carry, decrement, increment, test, half swap and clear. It takes either a byte operand or, for index-register forms, a 16-bit word. The caller supplies a 4-bit operation code, the operand, a width select and the current carry. The unit returns the result, the new N, Z and C flags, and a write mask. The mask tells the condition-code register which flags the operation actually changes.

All outputs come from one register stage. A request presented with `valid_i` high at a rising edge produces its result on the outputs right after that edge. The outputs then hold until the next valid request. Codes 1, 2, 5 and B do not belong to this unit. For those codes it raises an illegal indication and keeps every other output at zero, so a decoder can route them elsewhere.

Top module: `sop_alu`

## Requirements
- R1: A request with `valid_i`=1 at a rising edge appears on `result_o`, the flag outputs, `flag_we_o` and `illegal_o` after that same edge, and `valid_o` is 1 for that cycle. With `valid_i`=0, `valid_o` is 0 on the next cycle and the other outputs hold their values. After reset every output is 0.
- R2: Operation codes are: 0 negate, 3 complement, 4 logical right shift, 6 rotate right through carry, 7 arithmetic right shift, 8 left shift, 9 rotate left through carry, A decrement, C increment, D test, E swap, F clear. Codes 1, 2, 5 and B set `illegal_o`=1 and drive result, flags and mask to 0.
- R3: With `word_i`=1 the unit works on all 16 bits. With `word_i`=0 it works on `operand_i[7:0]`, ignores `operand_i[15:8]`, and drives `result_o[15:8]` to 0.
- R4: For every legal code, N is the top bit of the result at the selected width, and Z is 1 exactly when the result at that width is zero.
- R5: Negate returns the two's complement. It sets C when the operand is nonzero. Its mask is N,Z,C.
- R6: Complement returns the bitwise inverse and sets C to 1. Its mask is N,Z,C.
- R7: Both right shifts move the old bit 0 into C. The logical shift fills the top bit with 0, and the arithmetic shift keeps the top bit. Their mask is N,Z,C.
- R8: Left shift fills bit 0 with 0 and moves the old top bit into C. Its mask is N,Z,C.
- R9: Rotate right gives {C, operand[top:1]} with C taken from operand[0]. Rotate left gives {operand[top-1:0], C} with C taken from operand[top]. Their mask is N,Z,C.
- R10: Increment and decrement wrap at the selected width. Their mask is N,Z only, and `flag_c_o` equals `carry_i`.
- R11: Test returns the operand unchanged and clear returns 0. Both have mask N,Z, and for both `flag_c_o` equals `carry_i`.
- R12: Swap exchanges the two 4-bit halves of a byte, or the two 8-bit halves of a word. Its mask is N,Z, and `flag_c_o` equals `carry_i`.
- R13: `flag_we_o` bit 2 marks N, bit 1 marks Z and bit 0 marks C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| operand_i | input | 16 | Operand; low byte only in byte mode |
| word_i | input | 1 | 1 selects 16-bit width |
| carry_i | input | 1 | Incoming carry flag |
| valid_o | output | 1 | Result strobe |
| result_o | output | 16 | Operation result |
| flag_n_o | output | 1 | New N flag |
| flag_z_o | output | 1 | New Z flag |
| flag_c_o | output | 1 | New C flag |
| flag_we_o | output | 3 | Flag write mask {N,Z,C} |
| illegal_o | output | 1 | Code not handled by this unit |

## Verification
The output register is the only state in the unit, so any internal fault shows at the ports in the cycle right after the offending request. A wrong lane selection would corrupt either the upper result byte or the N flag, which comes from the wrong bit position. A wrong carry path would show up as C differing between the carry-in 0 and carry-in 1 runs of the rotates and of the carry-preserving operations. A fault in the hold logic would show when outputs change across idle cycles.

// File: rtl/sop_alu_pkg.sv
package sop_alu_pkg;
  localparam int OP_W   = 4;
  localparam int FLAG_N = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;
  localparam int FLAG_CNT = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NEG  = 4'h0,
    OP_CPL  = 4'h3,
    OP_SRL  = 4'h4,
    OP_RRC  = 4'h6,
    OP_SRA  = 4'h7,
    OP_SLL  = 4'h8,
    OP_RLC  = 4'h9,
    OP_DEC  = 4'hA,
    OP_INC  = 4'hC,
    OP_TNZ  = 4'hD,
    OP_SWAP = 4'hE,
    OP_CLR  = 4'hF
  } sop_op_e;

  function automatic logic op_legal(logic [OP_W-1:0] op);
    case (op)
      4'h1, 4'h2, 4'h5, 4'hB: return 1'b0;
      default:                return 1'b1;
    endcase
  endfunction

  function automatic logic op_writes_c(logic [OP_W-1:0] op);
    case (op)
      OP_NEG, OP_CPL, OP_SRL, OP_RRC, OP_SRA, OP_SLL, OP_RLC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sop_shift_unit.sv
module sop_shift_unit
  import sop_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    x_i,
  input  logic            carry_i,
  output logic [W-1:0]    res_o,
  output logic            c_o,
  output logic            hit_o
);
  localparam int HALF = W / 2;

  always_comb begin
    res_o = '0;
    c_o   = carry_i;
    hit_o = 1'b1;
    case (op_i)
      OP_SRL: begin res_o = {1'b0, x_i[W-1:1]};     c_o = x_i[0];   end
      OP_SRA: begin res_o = {x_i[W-1], x_i[W-1:1]}; c_o = x_i[0];   end
      OP_RRC: begin res_o = {carry_i, x_i[W-1:1]};  c_o = x_i[0];   end
      OP_SLL: begin res_o = {x_i[W-2:0], 1'b0};     c_o = x_i[W-1]; end
      OP_RLC: begin res_o = {x_i[W-2:0], carry_i};  c_o = x_i[W-1]; end
      OP_SWAP: res_o = {x_i[HALF-1:0], x_i[W-1:HALF]};
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sop_arith_unit.sv
module sop_arith_unit
  import sop_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    x_i,
  input  logic            carry_i,
  output logic [W-1:0]    res_o,
  output logic            c_o
);
  always_comb begin
    res_o = '0;
    c_o   = carry_i;
    case (op_i)
      OP_NEG: begin res_o = '0 - x_i; c_o = |x_i; end
      OP_CPL: begin res_o = ~x_i;     c_o = 1'b1; end
      OP_DEC: res_o = x_i - W'(1);
      OP_INC: res_o = x_i + W'(1);
      OP_TNZ: res_o = x_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/sop_lane.sv
module sop_lane
  import sop_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    x_i,
  input  logic            carry_i,
  output logic [W-1:0]    res_o,
  output logic            c_o
);
  logic [W-1:0] sh_res, ar_res;
  logic         sh_c, ar_c, sh_hit, legal;

  sop_shift_unit #(.W(W)) i_shift (
    .op_i(op_i), .x_i(x_i), .carry_i(carry_i),
    .res_o(sh_res), .c_o(sh_c), .hit_o(sh_hit)
  );

  sop_arith_unit #(.W(W)) i_arith (
    .op_i(op_i), .x_i(x_i), .carry_i(carry_i),
    .res_o(ar_res), .c_o(ar_c)
  );

  assign legal = op_legal(op_i);

  always_comb begin
    if (!legal) begin
      res_o = '0;
      c_o   = 1'b0;
    end else if (sh_hit) begin
      res_o = sh_res;
      c_o   = sh_c;
    end else begin
      res_o = ar_res;
      c_o   = ar_c;
    end
  end
endmodule

// File: rtl/sop_alu.sv
module sop_alu
  import sop_alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [WORD_W-1:0] operand_i,
  input  logic              word_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic [2:0]        flag_we_o,
  output logic              illegal_o
);
  localparam int BYTE_W  = WORD_W / 2;
  localparam int N_LANES = 2;

  logic [WORD_W-1:0] lane_res [N_LANES];
  logic              lane_c   [N_LANES];

  // lane 0: byte width, lane 1: word width
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? BYTE_W : WORD_W;
    logic [LW-1:0] res;
    sop_lane #(.W(LW)) i_lane (
      .op_i(op_i), .x_i(operand_i[LW-1:0]), .carry_i(carry_i),
      .res_o(res), .c_o(lane_c[g])
    );
    assign lane_res[g] = WORD_W'(res);
  end

  logic [WORD_W-1:0]   sel_res;
  logic                sel_c, legal, n_d, z_d;
  logic [FLAG_CNT-1:0] we_d;

  assign sel_res = word_i ? lane_res[1] : lane_res[0];
  assign sel_c   = word_i ? lane_c[1]   : lane_c[0];
  assign legal   = op_legal(op_i);

  always_comb begin
    we_d         = '0;
    we_d[FLAG_N] = legal;
    we_d[FLAG_Z] = legal;
    we_d[FLAG_C] = legal && op_writes_c(op_i);
  end

  assign n_d = legal && (word_i ? sel_res[WORD_W-1] : sel_res[BYTE_W-1]);
  assign z_d = legal && (word_i ? (sel_res == '0) : (sel_res[BYTE_W-1:0] == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      flag_n_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_c_o  <= 1'b0;
      flag_we_o <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= sel_res;
        flag_n_o  <= n_d;
        flag_z_o  <= z_d;
        flag_c_o  <= sel_c;
        flag_we_o <= we_d;
        illegal_o <= !legal;
      end
    end
  end
endmodule

// File: rtl/sop_alu_chk.sv
module sop_alu_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [WORD_W-1:0] operand_i,
  input logic              word_i,
  input logic              carry_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] result_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_c_o,
  input logic [2:0]        flag_we_o,
  input logic              illegal_o
);
  localparam int BYTE_W = WORD_W / 2;

  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flag_we_o) && !valid_o);

  p_illegal_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == '0 && flag_we_o == 3'b000 && !flag_n_o && !flag_z_o && !flag_c_o);

  p_byte_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !word_i |=> result_o[WORD_W-1:BYTE_W] == '0);

  p_zero_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o && result_o == '0 |-> flag_z_o);

  p_srl_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'h4 |=> !flag_n_o);

  p_inc_dec_keep_c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'hC || op_i == 4'hA) |=> flag_c_o == $past(carry_i) && flag_we_o == 3'b110);

  p_clr_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'hF |=> result_o == '0 && flag_z_o && !flag_n_o);

  p_mask_legal_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o |-> flag_we_o[2:1] == 2'b11);
endmodule

bind sop_alu sop_alu_chk #(.WORD_W(WORD_W)) i_sop_alu_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .operand_i(operand_i), .word_i(word_i), .carry_i(carry_i),
  .valid_o(valid_o), .result_o(result_o), .flag_n_o(flag_n_o),
  .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_we_o(flag_we_o),
  .illegal_o(illegal_o)
);

// File: tb/test_sop_alu.sv
module test_sop_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] operand_i = '0;
  logic        word_i = 1'b0;
  logic        carry_i = 1'b0;
  logic        valid_o, flag_n_o, flag_z_o, flag_c_o, illegal_o;
  logic [15:0] result_o;
  logic [2:0]  flag_we_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  sop_alu i_sop_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .word_i(word_i), .carry_i(carry_i),
    .valid_o(valid_o), .result_o(result_o), .flag_n_o(flag_n_o),
    .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_we_o(flag_we_o),
    .illegal_o(illegal_o)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic ref_model(input logic [3:0] op, input logic [15:0] x_in, input logic w, input logic c,
                           output logic [15:0] r, output logic n, output logic z, output logic co,
                           output logic [2:0] we, output logic ill, output string tag);
    logic [15:0] m, top, x;
    m   = w ? 16'hFFFF : 16'h00FF;
    top = w ? 16'h8000 : 16'h0080;
    x   = x_in & m;
    co  = c;
    we  = 3'b110;
    ill = 1'b0;
    r   = '0;
    case (op)
      4'h0: begin r = (16'h0 - x) & m; co = (x != 0); we = 3'b111; tag = "R5"; end
      4'h3: begin r = ~x & m; co = 1'b1; we = 3'b111; tag = "R6"; end
      4'h4: begin r = x >> 1; co = x[0]; we = 3'b111; tag = "R7"; end
      4'h7: begin r = (x >> 1) | (x & top); co = x[0]; we = 3'b111; tag = "R7"; end
      4'h8: begin r = (x << 1) & m; co = (x & top) != 0; we = 3'b111; tag = "R8"; end
      4'h6: begin r = (x >> 1) | (c ? top : 16'h0); co = x[0]; we = 3'b111; tag = "R9"; end
      4'h9: begin r = ((x << 1) | {15'h0, c}) & m; co = (x & top) != 0; we = 3'b111; tag = "R9"; end
      4'hA: begin r = (x - 16'h1) & m; tag = "R10"; end
      4'hC: begin r = (x + 16'h1) & m; tag = "R10"; end
      4'hD: begin r = x; tag = "R11"; end
      4'hF: begin r = '0; tag = "R11"; end
      4'hE: begin r = w ? {x[7:0], x[15:8]} : {8'h00, x[3:0], x[7:4]}; tag = "R12"; end
      default: begin co = 1'b0; we = 3'b000; ill = 1'b1; tag = "R2"; end
    endcase
    n = !ill && ((r & top) != 0);
    z = !ill && (r == 0);
  endtask

  task automatic issue(input logic [3:0] op, input logic [15:0] x, input logic w, input logic c);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; operand_i = x; word_i = w; carry_i = c;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic run_one(input logic [3:0] op, input logic [15:0] x, input logic w, input logic c);
    logic [15:0] r; logic n, z, co, ill; logic [2:0] we; string tag;
    ref_model(op, x, w, c, r, n, z, co, we, ill, tag);
    issue(op, x, w, c);
    check("R1", "valid", {15'h0, valid_o}, 16'h1);
    check(tag, "result", result_o, r);
    check("R4", "n", {15'h0, flag_n_o}, {15'h0, n});
    check("R4", "z", {15'h0, flag_z_o}, {15'h0, z});
    check(tag, "c", {15'h0, flag_c_o}, {15'h0, co});
    check("R13", "mask", {13'h0, flag_we_o}, {13'h0, we});
    check("R2", "illegal", {15'h0, illegal_o}, {15'h0, ill});
  endtask

  task automatic t_reset;
    check("R1", "reset valid", {15'h0, valid_o}, 16'h0);
    check("R1", "reset result", result_o, 16'h0);
    check("R1", "reset mask", {13'h0, flag_we_o}, 16'h0);
  endtask

  task automatic t_sweep;
    logic [15:0] pats [8] = '{16'h0000, 16'h0001, 16'h0080, 16'h00FF,
                              16'h8000, 16'hFFFF, 16'hA5C3, 16'h7F01};
    for (int op = 0; op < 16; op++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 2; c++)
          for (int p = 0; p < 8; p++)
            run_one(4'(op), pats[p], w[0], c[0]);
  endtask

  task automatic t_illegal;
    run_one(4'h1, 16'h1234, 1'b1, 1'b1);
    run_one(4'h2, 16'hFFFF, 1'b0, 1'b1);
    run_one(4'h5, 16'h0080, 1'b1, 1'b0);
    run_one(4'hB, 16'h00FF, 1'b0, 1'b1);
  endtask

  task automatic t_byte_upper_ignored;
    // R3: upper operand byte must not leak in byte mode
    run_one(4'hE, 16'hAB12, 1'b0, 1'b0);
    check("R3", "swap byte", result_o, 16'h0021);
    run_one(4'h7, 16'h7F81, 1'b0, 1'b0);
    check("R3", "sra byte", result_o, 16'h00C0);
    run_one(4'hC, 16'h12FF, 1'b0, 1'b1);
    check("R3", "inc wrap", result_o, 16'h0000);
  endtask

  task automatic t_hold;
    logic [15:0] r;
    run_one(4'h9, 16'h4001, 1'b1, 1'b1);
    r = result_o;
    @(negedge clk_i);
    operand_i = 16'hFFFF; op_i = 4'h0;
    @(negedge clk_i);
    check("R1", "idle valid", {15'h0, valid_o}, 16'h0);
    check("R1", "hold result", result_o, r);
    check("R1", "hold mask", {13'h0, flag_we_o}, 16'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_sweep();
    t_illegal();
    t_byte_upper_ignored();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule